// File: doc/BRIEF.md
# Message Object Transfer Controller

This block moves message objects between a CPU-visible register window and a 32-entry message object RAM. Two interface register sets, each with a command register and buffers for the acceptance mask and the arbitration identifier, give the CPU two independent staging areas. A write to a set's command register starts a copy between that set's buffers and one RAM object. The copy runs in one of two directions: from the buffers into the RAM, or from the RAM into the buffers.

There is a single RAM port. The protocol core reaches the same RAM for transmission, acceptance filtering and message storage. It raises `core_req`, and it always takes the port ahead of any interface copy. When both sets are waiting for the port, the first set is served first. A request made while another copy is in flight waits until that copy ends. Object numbers outside 1..32 are folded onto a valid object and are never rejected. When wait mode is on, a CPU access to a busy set raises a stall output until the copy has finished.

Top module: `mot_ctrl`

## Requirements
- R1: A write to a set's command register (byte offset +0x0) sets Busy (bit 15) from the following cycle. Busy returns to 0 when the copy ends. The command register reads back as Busy in bit 15, the direction in bit 7 and the object number in bits 5:0, with all other bits 0. After reset it reads 0x0001.
- R2: Object number 0 is handled as 32, and numbers 33..63 are handled as the number minus 32. The command register reads back the folded number, and the RAM object used is the folded number minus 1.
- R3: With direction bit 7 = 0, the copy loads all mask and identifier fields of the object into the buffers in one cycle. With the port free, Busy is seen clear two cycles after the command write edge.
- R4: With direction bit 7 = 1, the buffers are written to the object as a 63-bit word. From MSB to LSB the word holds mask-extended, mask-direction, mask[28:0], valid, extended, direction, identifier[28:0]. With the port free, Busy is seen clear one cycle after the command write edge.
- R5: The block never accesses the RAM in a cycle where `core_req` is high, and `core_gnt` follows `core_req`. If the core holds the port for the first three cycles of a read copy, Busy clears four cycles after the command write edge.
- R6: When both sets are waiting for the port, the first set is served first. A second set's request made while a copy is in flight starts only after that copy completes.
- R7: The set bases are 0x10 and 0x40. The offsets are +0x4 for mask[15:0], +0x6 for {mask-extended bit 15, mask-direction bit 14, 0 at bit 13, mask[28:16]}, +0x8 for identifier[15:0], and +0xA for {valid bit 15, extended bit 14, direction bit 13, identifier[28:16]}. Any other address reads 0.
- R8: With `wait_en` high, `cpu_stall` is high while a read or write targets a set whose Busy is 1. Otherwise `cpu_stall` is low.
- R9: CPU writes to the buffers or the command register of a busy set have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe (used for stall) |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, combinational from address |
| wait_en | input | 1 | Enables the stall output |
| cpu_stall | output | 1 | CPU wait request |
| core_req | input | 1 | Protocol core requests the RAM port |
| core_gnt | output | 1 | Port granted to the core |
| mo_en | output | 1 | RAM access strobe |
| mo_we | output | 1 | RAM write enable |
| mo_idx | output | 5 | RAM object index |
| mo_wdata | output | 63 | RAM write word |
| mo_rdata | input | 63 | RAM read word, valid one cycle after a read strobe |

## Verification
The assertions check the port-level rules on every cycle. The block never accesses the RAM while the core holds it. At most one set is issued at a time, and the second set is never issued while the first is waiting. Every RAM read is followed by exactly one buffer load. A busy set's buffers stay frozen, and the stall output is only raised while wait mode is on and a set is busy. Other behaviour can only be shown by the bench's scenarios. These cover the folding of odd object numbers onto real objects and the exact completion cycles with and without core contention. They also cover the order in which queued requests finish, the register layout and the data that reaches the RAM or comes back from it.

// File: rtl/mot_pkg.sv
// Shared types and constants for the message object transfer controller.
// Assumes a 16-bit CPU register width and 29-bit identifiers and masks.
package mot_pkg;
    localparam int REG_W     = 16;
    localparam int NUM_W     = 6;
    localparam int IDX_W     = 5;
    localparam int ID_W      = 29;
    localparam int HI_W      = ID_W - 16;

    localparam int OFS_CMD    = 0;
    localparam int OFS_MSK_LO = 4;
    localparam int OFS_MSK_HI = 6;
    localparam int OFS_ARB_LO = 8;
    localparam int OFS_ARB_HI = 10;
    localparam int WIN_BYTES  = 12;

    localparam int CMD_BUSY_BIT = 15;
    localparam int CMD_DIR_BIT  = 7;

    // One message object as stored in the RAM, MSB first.
    typedef struct packed {
        logic            mxtd;
        logic            mdir;
        logic [ID_W-1:0] msk;
        logic            msgval;
        logic            xtd;
        logic            dir;
        logic [ID_W-1:0] id;
    } mobj_t;

    localparam int OBJ_W = $bits(mobj_t);

    typedef enum logic {ST_IDLE, ST_CAPT} xfer_st_t;

    // Folds any 6-bit object number onto a RAM index 0..31.
    function automatic logic [IDX_W-1:0] num_to_idx(input logic [NUM_W-1:0] raw);
        return raw[IDX_W-1:0] - IDX_W'(1);
    endfunction

    // Folded object number in the range 1..32.
    function automatic logic [NUM_W-1:0] num_fold(input logic [NUM_W-1:0] raw);
        return {1'b0, num_to_idx(raw)} + NUM_W'(1);
    endfunction
endpackage

// File: rtl/mot_if_regs.sv
// One interface register set: command register, mask and arbitration buffers.
// Decodes its own address window at BASE. Writes are dropped while busy.
// Assumes the CPU only issues even (16-bit aligned) addresses.
module mot_if_regs
    import mot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BASE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic              hit,
    output logic [REG_W-1:0]  rdata,
    output logic              busy,
    output logic              pend,
    output logic              to_ram,
    output logic [IDX_W-1:0]  obj_idx,
    output mobj_t             buf_q,
    input  logic              issue,
    input  logic              done,
    input  logic              load,
    input  mobj_t             load_obj
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(WIN_BYTES);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_MLO  = ADDR_W'(OFS_MSK_LO);
    localparam logic [ADDR_W-1:0] A_MHI  = ADDR_W'(OFS_MSK_HI);
    localparam logic [ADDR_W-1:0] A_ALO  = ADDR_W'(OFS_ARB_LO);
    localparam logic [ADDR_W-1:0] A_AHI  = ADDR_W'(OFS_ARB_HI);

    logic [ADDR_W-1:0] ofs;
    logic              wr_ok;
    logic              busy_q;
    logic              inflight_q;
    logic              dir_q;
    logic [NUM_W-1:0]  num_q;

    assign ofs   = cpu_addr - BASE_A;
    assign hit   = (cpu_addr >= BASE_A) && (ofs < WIN_A);
    assign wr_ok = cpu_wr && hit && !busy_q;

    // Command register: busy flag, direction, folded object number, in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            inflight_q <= 1'b0;
            dir_q      <= 1'b0;
            num_q      <= NUM_W'(1);
        end else begin
            if (wr_ok && (ofs == A_CMD)) begin
                busy_q <= 1'b1;
                dir_q  <= cpu_wdata[CMD_DIR_BIT];
                num_q  <= num_fold(cpu_wdata[NUM_W-1:0]);
            end else if (done) begin
                busy_q <= 1'b0;
            end
            if (done) begin
                inflight_q <= 1'b0;
            end else if (issue) begin
                inflight_q <= 1'b1;
            end
        end
    end

    // Buffer registers: loaded whole from the RAM or field-wise from the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (load) begin
            buf_q <= load_obj;
        end else if (wr_ok) begin
            case (ofs)
                A_MLO: buf_q.msk[15:0] <= cpu_wdata;
                A_MHI: begin
                    buf_q.mxtd          <= cpu_wdata[15];
                    buf_q.mdir          <= cpu_wdata[14];
                    buf_q.msk[ID_W-1:16] <= cpu_wdata[HI_W-1:0];
                end
                A_ALO: buf_q.id[15:0] <= cpu_wdata;
                A_AHI: begin
                    buf_q.msgval        <= cpu_wdata[15];
                    buf_q.xtd           <= cpu_wdata[14];
                    buf_q.dir           <= cpu_wdata[13];
                    buf_q.id[ID_W-1:16] <= cpu_wdata[HI_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Read mux for this window; zero outside it and on unused offsets.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (ofs)
                A_CMD: begin
                    rdata[CMD_BUSY_BIT] = busy_q;
                    rdata[CMD_DIR_BIT]  = dir_q;
                    rdata[NUM_W-1:0]    = num_q;
                end
                A_MLO: rdata = buf_q.msk[15:0];
                A_MHI: begin
                    rdata[15]       = buf_q.mxtd;
                    rdata[14]       = buf_q.mdir;
                    rdata[HI_W-1:0] = buf_q.msk[ID_W-1:16];
                end
                A_ALO: rdata = buf_q.id[15:0];
                A_AHI: begin
                    rdata[15]       = buf_q.msgval;
                    rdata[14]       = buf_q.xtd;
                    rdata[13]       = buf_q.dir;
                    rdata[HI_W-1:0] = buf_q.id[ID_W-1:16];
                end
                default: rdata = '0;
            endcase
        end
    end

    assign busy    = busy_q;
    assign pend    = busy_q && !inflight_q;
    assign to_ram  = dir_q;
    assign obj_idx = num_to_idx(num_q);
endmodule

// File: rtl/mot_port_arb.sv
// Single RAM port arbiter and transfer sequencer.
// The core always wins; among the sets the lowest index wins. A RAM write
// completes in the issue cycle; a RAM read returns data one cycle later,
// which is captured into the owning set while the port stays closed.
module mot_port_arb
    import mot_pkg::*;
#(
    parameter int NUM_IF = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           core_req,
    input  logic [NUM_IF-1:0]              pend,
    input  logic [NUM_IF-1:0]              to_ram,
    input  logic [NUM_IF-1:0][IDX_W-1:0]   idx,
    input  mobj_t [NUM_IF-1:0]             bufs,
    input  mobj_t                          rd_obj,
    output logic [NUM_IF-1:0]              issue,
    output logic [NUM_IF-1:0]              done,
    output logic [NUM_IF-1:0]              load,
    output mobj_t                          load_obj,
    output logic                           mo_en,
    output logic                           mo_we,
    output logic [IDX_W-1:0]               mo_idx,
    output mobj_t                          mo_wdata
);
    localparam int SEL_W = (NUM_IF > 1) ? $clog2(NUM_IF) : 1;

    xfer_st_t         st_q;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] sel_q;
    logic             any_pend;
    logic             go;

    // Fixed priority pick: lowest-numbered waiting set.
    always_comb begin
        any_pend = 1'b0;
        sel      = '0;
        for (int i = NUM_IF - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any_pend = 1'b1;
                sel      = SEL_W'(i);
            end
        end
    end

    assign go       = (st_q == ST_IDLE) && !core_req && any_pend;
    assign mo_en    = go;
    assign mo_we    = go && to_ram[sel];
    assign mo_idx   = idx[sel];
    assign mo_wdata = bufs[sel];
    assign load_obj = rd_obj;

    // Per-set issue, completion and capture strobes.
    always_comb begin
        issue = '0;
        done  = '0;
        load  = '0;
        if (go) begin
            issue[sel] = 1'b1;
            if (to_ram[sel]) begin
                done[sel] = 1'b1;
            end
        end
        if (st_q == ST_CAPT) begin
            done[sel_q] = 1'b1;
            load[sel_q] = 1'b1;
        end
    end

    // Sequencer state: wait one cycle for read data after a RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sel_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (go && !to_ram[sel]) begin
                    st_q  <= ST_CAPT;
                    sel_q <= sel;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mot_ctrl.sv
// Top of the message object transfer controller.
// NUM_IF register sets sit at IF_BASE + n*IF_STRIDE and share one RAM port
// with the protocol core. Assumes the RAM returns read data after one cycle.
module mot_ctrl
    import mot_pkg::*;
#(
    parameter int NUM_IF    = 2,
    parameter int ADDR_W    = 8,
    parameter int IF_BASE   = 16,
    parameter int IF_STRIDE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              wait_en,
    output logic              cpu_stall,
    input  logic              core_req,
    output logic              core_gnt,
    output logic              mo_en,
    output logic              mo_we,
    output logic [IDX_W-1:0]  mo_idx,
    output logic [OBJ_W-1:0]  mo_wdata,
    input  logic [OBJ_W-1:0]  mo_rdata
);
    logic [NUM_IF-1:0]             hit_v;
    logic [NUM_IF-1:0]             busy_v;
    logic [NUM_IF-1:0]             pend_v;
    logic [NUM_IF-1:0]             dir_v;
    logic [NUM_IF-1:0]             issue_v;
    logic [NUM_IF-1:0]             done_v;
    logic [NUM_IF-1:0]             load_v;
    logic [NUM_IF-1:0][IDX_W-1:0]  idx_v;
    logic [NUM_IF-1:0][REG_W-1:0]  rd_v;
    mobj_t [NUM_IF-1:0]            buf_v;
    mobj_t                         load_obj;
    mobj_t                         wobj;

    for (genvar g = 0; g < NUM_IF; g++) begin : g_if
        mot_if_regs #(
            .ADDR_W (ADDR_W),
            .BASE   (IF_BASE + g * IF_STRIDE)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .cpu_wr   (cpu_wr),
            .cpu_addr (cpu_addr),
            .cpu_wdata(cpu_wdata),
            .hit      (hit_v[g]),
            .rdata    (rd_v[g]),
            .busy     (busy_v[g]),
            .pend     (pend_v[g]),
            .to_ram   (dir_v[g]),
            .obj_idx  (idx_v[g]),
            .buf_q    (buf_v[g]),
            .issue    (issue_v[g]),
            .done     (done_v[g]),
            .load     (load_v[g]),
            .load_obj (load_obj)
        );
    end

    mot_port_arb #(.NUM_IF(NUM_IF)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_req (core_req),
        .pend     (pend_v),
        .to_ram   (dir_v),
        .idx      (idx_v),
        .bufs     (buf_v),
        .rd_obj   (mo_rdata),
        .issue    (issue_v),
        .done     (done_v),
        .load     (load_v),
        .load_obj (load_obj),
        .mo_en    (mo_en),
        .mo_we    (mo_we),
        .mo_idx   (mo_idx),
        .mo_wdata (wobj)
    );

    // Merge the read data of all windows (windows never overlap).
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NUM_IF; i++) begin
            cpu_rdata = cpu_rdata | rd_v[i];
        end
    end

    assign mo_wdata  = wobj;
    assign core_gnt  = core_req;
    assign cpu_stall = wait_en && (cpu_wr || cpu_rd) && |(hit_v & busy_v);
endmodule

// File: rtl/mot_ctrl_checker.sv
// Protocol checker for mot_ctrl, bound to every instance of it.
module mot_ctrl_checker
    import mot_pkg::*;
#(
    parameter int NUM_IF = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_req,
    input logic              mo_en,
    input logic              mo_we,
    input logic              wait_en,
    input logic              cpu_stall,
    input logic [NUM_IF-1:0] busy_v,
    input logic [NUM_IF-1:0] pend_v,
    input logic [NUM_IF-1:0] issue_v,
    input logic [NUM_IF-1:0] load_v,
    input mobj_t [NUM_IF-1:0] buf_v
);
    // R5: the core owns the port whenever it asks for it.
    assert_core_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mo_en |-> !core_req);

    // R6: one set at a time on the port.
    assert_single_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_v));

    // R6: the second set is never issued while the first is waiting.
    assert_first_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_v[1] |-> !pend_v[0]);

    // R3: each RAM read is followed by exactly one buffer load.
    assert_read_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mo_en && !mo_we) |=> ($countones(load_v) == 1));

    // R8: a stall only happens in wait mode with some set busy.
    assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (wait_en && (|busy_v)));

    // R9: a busy set's buffers do not move until the copy ends.
    for (genvar g = 0; g < NUM_IF; g++) begin : g_chk
        assert_buf_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_v[g] && $past(busy_v[g])) |-> $stable(buf_v[g]));
    end
endmodule

bind mot_ctrl mot_ctrl_checker #(.NUM_IF(NUM_IF)) u_mot_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_req (core_req),
    .mo_en    (mo_en),
    .mo_we    (mo_we),
    .wait_en  (wait_en),
    .cpu_stall(cpu_stall),
    .busy_v   (busy_v),
    .pend_v   (pend_v),
    .issue_v  (issue_v),
    .load_v   (load_v),
    .buf_v    (buf_v)
);

// File: tb/mot_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench for mot_ctrl: directed corners plus seeded random copies.
module mot_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_wr, cpu_rd;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic        wait_en, cpu_stall;
    logic        core_force, core_rnd, rnd_en, core_req, core_gnt;
    logic        mo_en, mo_we;
    logic [4:0]  mo_idx;
    logic [62:0] mo_wdata, mo_rdata;
    logic [62:0] ram [32];
    logic [62:0] exp_ram [32];
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    assign core_req = core_force | core_rnd;

    mot_ctrl u_mot_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .wait_en(wait_en), .cpu_stall(cpu_stall), .core_req(core_req),
        .core_gnt(core_gnt), .mo_en(mo_en), .mo_we(mo_we), .mo_idx(mo_idx),
        .mo_wdata(mo_wdata), .mo_rdata(mo_rdata)
    );

    // RAM model with one cycle read latency.
    always @(posedge clk) begin
        if (mo_en) begin
            if (mo_we) ram[mo_idx] <= mo_wdata;
            else       mo_rdata    <= ram[mo_idx];
        end
    end

    // Random core traffic for the random phase.
    always @(negedge clk) core_rnd <= rnd_en && ($urandom_range(3) == 0);

    function automatic logic [7:0] base(input int i);
        return 8'h10 + 8'(i * 48);
    endfunction

    function automatic logic [5:0] exp_norm(input logic [5:0] raw);
        if (raw == 6'd0)  return 6'd32;
        if (raw > 6'd32)  return raw - 6'd32;
        return raw;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr16(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd16(input logic [7:0] a, output logic [15:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        d = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic wait_idle(input int ifn, output int n);
        logic [15:0] d;
        n = 0;
        do begin
            @(negedge clk);
            rd16(base(ifn), d);
            n++;
        end while (d[15] && n < 40);
        chk("R5 copy completes", 64'(n < 40), 64'd1);
    endtask

    task automatic load_buf(input int ifn, input logic [62:0] o);
        wr16(base(ifn) + 8'd4, o[47:32]);
        wr16(base(ifn) + 8'd6, {o[62], o[61], 1'b0, o[60:48]});
        wr16(base(ifn) + 8'd8, o[15:0]);
        wr16(base(ifn) + 8'd10, {o[31], o[30], o[29], o[28:16]});
    endtask

    task automatic read_buf(input int ifn, output logic [62:0] o);
        logic [15:0] ml, mh, al, ah;
        rd16(base(ifn) + 8'd4, ml);
        rd16(base(ifn) + 8'd6, mh);
        rd16(base(ifn) + 8'd8, al);
        rd16(base(ifn) + 8'd10, ah);
        chk("R7 mask reserved bit", 64'(mh[13]), 64'd0);
        o = {mh[15], mh[14], mh[12:0], ml, ah[15], ah[14], ah[13], ah[12:0], al};
    endtask

    task automatic do_xfer(input int ifn, input logic [5:0] num, input logic w, output int n);
        logic [15:0] d;
        wr16(base(ifn), {8'h00, w, 1'b0, num});
        rd16(base(ifn), d);
        chk("R1 busy set after command", 64'(d[15]), 64'd1);
        wait_idle(ifn, n);
        rd16(base(ifn), d);
        chk("R2 command readback folded", 64'(d), 64'({8'h00, w, 1'b0, exp_norm(num)}));
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [62:0] o, got;
        int          n;
        void'($urandom(32'd4711));
        rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        wait_en = 1'b0; core_force = 1'b0; core_rnd = 1'b0; rnd_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R7 unused addresses
        rd16(8'h10, d); chk("R1 reset cmd set 1", 64'(d), 64'h0001);
        rd16(8'h40, d); chk("R1 reset cmd set 2", 64'(d), 64'h0001);
        rd16(8'h12, d); chk("R7 unused offset", 64'(d), 64'h0);
        rd16(8'h20, d); chk("R7 unmapped address", 64'(d), 64'h0);

        // R4 fill all objects through both sets, one-cycle write copies
        for (int k = 0; k < 32; k++) begin
            o = {$urandom, $urandom};
            load_buf(k % 2, o);
            do_xfer(k % 2, 6'(k + 1), 1'b1, n);
            chk("R4 write timing", 64'(n), 64'd1);
            chk("R4 word in RAM", 64'(ram[k]), 64'(o));
            exp_ram[k] = o;
        end

        // R2 + R3 folded numbers on read copies
        do_xfer(1, 6'd0, 1'b0, n);
        chk("R3 read timing", 64'(n), 64'd2);
        read_buf(1, got); chk("R2 number 0 is object 32", 64'(got), 64'(exp_ram[31]));
        do_xfer(0, 6'h21, 1'b0, n);
        read_buf(0, got); chk("R2 number 0x21 is object 1", 64'(got), 64'(exp_ram[0]));
        do_xfer(0, 6'h3F, 1'b0, n);
        read_buf(0, got); chk("R2 number 0x3F is object 31", 64'(got), 64'(exp_ram[30]));

        // R5 core holds the port for three cycles
        @(negedge clk);
        core_force = 1'b1; cpu_addr = 8'h10; cpu_wdata = 16'h0007; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R5 no RAM access under core", 64'(mo_en), 64'd0);
        chk("R5 core granted", 64'(core_gnt), 64'd1);
        @(negedge clk);
        @(negedge clk);
        rd16(8'h10, d); chk("R5 still busy under core", 64'(d[15]), 64'd1);
        core_force = 1'b0;
        wait_idle(0, n);
        chk("R5 completion after release", 64'(n), 64'd2);
        read_buf(0, got); chk("R5 data after contention", 64'(got), 64'(exp_ram[6]));

        // R6 back-to-back commands on both sets
        @(negedge clk);
        cpu_addr = 8'h10; cpu_wdata = 16'h0005; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_addr = 8'h40; cpu_wdata = 16'h0006;
        @(negedge clk);
        cpu_wr = 1'b0;
        rd16(8'h40, d); chk("R6 second set queued", 64'(d[15]), 64'd1);
        @(negedge clk);
        rd16(8'h10, d); chk("R6 first set done", 64'(d[15]), 64'd0);
        rd16(8'h40, d); chk("R6 second set waits", 64'(d[15]), 64'd1);
        @(negedge clk);
        @(negedge clk);
        rd16(8'h40, d); chk("R6 second set done", 64'(d[15]), 64'd0);
        read_buf(0, got); chk("R6 first set data", 64'(got), 64'(exp_ram[4]));
        read_buf(1, got); chk("R6 second set data", 64'(got), 64'(exp_ram[5]));

        // R6 both waiting at once: first set is served first
        core_force = 1'b1;
        wr16(8'h40, 16'h000A);
        wr16(8'h10, 16'h000B);
        core_force = 1'b0;
        wait_idle(0, n);
        rd16(8'h40, d); chk("R6 first set wins tie", 64'(d[15]), 64'd1);
        wait_idle(1, n);
        read_buf(1, got); chk("R6 tie loser data", 64'(got), 64'(exp_ram[9]));

        // R8 stall output
        core_force = 1'b1;
        wr16(8'h10, 16'h0004);
        wait_en = 1'b1;
        cpu_addr = 8'h14; cpu_rd = 1'b1; #1;
        chk("R8 stall on busy set", 64'(cpu_stall), 64'd1);
        cpu_addr = 8'h44; #1;
        chk("R8 no stall on idle set", 64'(cpu_stall), 64'd0);
        wait_en = 1'b0; cpu_addr = 8'h14; #1;
        chk("R8 no stall with wait off", 64'(cpu_stall), 64'd0);
        cpu_rd = 1'b0;
        core_force = 1'b0;
        wait_idle(0, n);

        // R9 writes to a busy set are dropped
        o = {$urandom, $urandom};
        load_buf(0, o);
        core_force = 1'b1;
        wr16(8'h10, 16'h0083);
        wr16(8'h14, ~o[47:32]);
        wr16(8'h1A, ~o[31:16]);
        wr16(8'h10, 16'h0009);
        rd16(8'h10, d); chk("R9 command kept while busy", 64'(d), 64'h8083);
        core_force = 1'b0;
        wait_idle(0, n);
        chk("R9 RAM got original buffer", 64'(ram[2]), 64'(o));
        read_buf(0, got); chk("R9 buffer unchanged", 64'(got), 64'(o));
        exp_ram[2] = o;

        // Random mix with random core traffic
        rnd_en = 1'b1;
        for (int k = 0; k < 80; k++) begin
            int          ifn;
            logic [5:0]  num;
            int          ix;
            ifn = $urandom_range(1);
            num = 6'($urandom_range(63));
            ix  = int'(exp_norm(num)) - 1;
            if ($urandom_range(1) == 1) begin
                o = {$urandom, $urandom};
                load_buf(ifn, o);
                do_xfer(ifn, num, 1'b1, n);
                chk("R4 random write", 64'(ram[ix]), 64'(o));
                exp_ram[ix] = o;
            end else begin
                do_xfer(ifn, num, 1'b0, n);
                read_buf(ifn, got);
                chk("R3 random read", 64'(got), 64'(exp_ram[ix]));
            end
        end
        rnd_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule